// File: doc/BRIEF.md
# Expansion Bus Slave Interface

This block sits on a plug-in card attached to a 16-bit asynchronous-style expansion bus, sampled on the card's own clock. It compares the upper address bits against an assigned window. When the bus master is the processor, it also uses the memory-space code to reject interrupt-acknowledge space. It turns each data-strobe transfer into a single internal access pulse, with a word address, a write flag, byte enables and lane-masked write data. On reads it drives the bus with data returned by the internal resource, but only while the external output-enable permits.

A slow internal resource is covered by a programmable count of wait clocks. The card holds off the bus acknowledge in one of two ways, chosen by a parameter. It can pull the shared ready line low until the access completes. Or it can pull the override line for the whole cycle and pull its own acknowledge once the data is ready. Both lines are only ever pulled low or released.

The address strobe may stay low across several transfers, as in a locked read-modify-write. The block therefore starts a new transfer each time a data strobe goes active, and not on the address strobe.

Top module: `ebs_slave`

## Requirements
- R1: The block responds only when the address strobe is low and address bits [22:19] of `addr` equal the `BASE` parameter (default 4'hA). Any other address gives no access pulse and no pulled line.
- R2: The space code is considered only while `bgack_n` is high (processor master). In that case a code of 3'b111 is not selected. While `bgack_n` is low the code is ignored.
- R3: `acc_be[0]` is the inverse of `lds_n` and covers the even byte `dbus_in[7:0]`. `acc_be[1]` is the inverse of `uds_n` and covers the odd byte `dbus_in[15:8]`. This holds for reads and writes alike.
- R4: Write data is captured on the first clock edge that sees a data strobe low. Disabled byte lanes of `acc_wdata` read as zero.
- R5: `acc_stb` is high in the clock that follows WAIT_CLKS+1 edges after the first edge that sees a data strobe low (WAIT_CLKS from 0 to 15).
- R6: In ready mode, `rdy_pull` is high while the block is selected and no completed access is awaiting strobe release. It drops in the clock after `acc_stb`.
- R7: In override mode, `ovr_pull` is high for the whole selected cycle. `ack_pull` is high only from the clock after `acc_stb` until the data strobes negate. `rdy_pull` stays low.
- R8: `dbus_oe` is high only for a selected read with `doe` high and a data strobe low, after the access completes. It drops in the same clock the strobes negate. `dbus_out` then carries the `acc_rdata` value sampled during `acc_stb`.
- R9: A high address strobe releases `rdy_pull`, `ovr_pull`, `ack_pull` and `dbus_oe` in the same clock. A transfer that has not yet pulsed is abandoned without a pulse.
- R10: Under one low address strobe, each low period of the data strobes produces its own access pulse. A read followed by a write gives two pulses, with `acc_we` 0 then 1.
- R11: Each access pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Odd-byte data strobe, active low |
| lds_n | input | 1 | Even-byte data strobe, active low |
| rd | input | 1 | 1 for read, 0 for write |
| addr | input | 23 | Word address, bus bits 23..1 |
| fc | input | 3 | Memory-space code |
| bgack_n | input | 1 | Low while a DMA master owns the bus |
| doe | input | 1 | Data output enable from the backplane |
| dbus_in | input | 16 | Data bus as received |
| dbus_out | output | 16 | Read data to drive on the bus |
| dbus_oe | output | 1 | Data bus driver enable |
| acc_stb | output | 1 | Internal access pulse |
| acc_we | output | 1 | Internal access is a write |
| acc_be | output | 2 | Internal byte enables |
| acc_addr | output | 23 | Internal access word address |
| acc_wdata | output | 16 | Lane-masked write data |
| acc_rdata | input | 16 | Read data from the internal resource |
| rdy_pull | output | 1 | Pull the ready line low |
| ovr_pull | output | 1 | Pull the override line low |
| ack_pull | output | 1 | Pull the acknowledge line low |

## Verification
The hardest situation to reach is a locked read-modify-write, where the address strobe stays low while the data strobes rise and fall again and the read/write line flips between transfers. The bench builds this by hand. It holds the address strobe low, completes a read, releases the data strobes, then sets up write data and reasserts them. It confirms two separate pulses and that the ready hold-off returns between them. A second case raises the address strobe during the wait count, to show that the transfer is abandoned and every pulled line lets go at once.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    localparam int ADDR_W = 23;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_ACC  = 2'd2,
        ST_DONE = 2'd3
    } xfer_st_e;

    typedef enum logic {
        WM_READY    = 1'b0,
        WM_OVERRIDE = 1'b1
    } wait_mode_e;

    typedef struct packed {
        logic              we;
        logic [LANES-1:0]  be;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_req_t;

    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be,
                                                    input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < LANES; i++) begin
            m[i*8 +: 8] = be[i] ? d[i*8 +: 8] : 8'h00;
        end
        return m;
    endfunction

endpackage

// File: rtl/ebs_decode.sv
module ebs_decode
    import ebs_pkg::*;
#(
    parameter int                  DEC_BITS = 4,
    parameter logic [DEC_BITS-1:0] BASE     = 'hA
) (
    input  logic              as_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        fc,
    input  logic              bgack_n,
    output logic              sel
);
    localparam int LO = ADDR_W - DEC_BITS;

    logic win_hit;
    logic space_ok;

    assign win_hit  = (addr[ADDR_W-1:LO] == BASE);
    assign space_ok = !bgack_n || (fc != 3'b111);
    assign sel      = !as_n && win_hit && space_ok;
endmodule

// File: rtl/ebs_xfer_ctl.sv
module ebs_xfer_ctl
    import ebs_pkg::*;
#(
    parameter int WAIT_CLKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dbus_in,
    input  logic [DATA_W-1:0] acc_rdata,
    output xfer_st_e          state,
    output xfer_req_t         req,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int CW = (WAIT_CLKS > 0) ? $clog2(WAIT_CLKS + 1) : 1;

    logic [CW-1:0]    cnt;
    logic             ds_any;
    logic [LANES-1:0] be_now;

    assign ds_any = !(uds_n && lds_n);
    assign be_now = {!uds_n, !lds_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            req     <= '0;
            rdata_q <= '0;
        end else if (!sel) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ds_any) begin
                        req.we    <= !rd;
                        req.be    <= be_now;
                        req.addr  <= addr;
                        req.wdata <= lane_mask(be_now, dbus_in);
                        cnt       <= CW'(WAIT_CLKS);
                        state     <= (WAIT_CLKS == 0) ? ST_ACC : ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (cnt <= CW'(1)) state <= ST_ACC;
                    else               cnt   <= cnt - CW'(1);
                end
                ST_ACC: begin
                    if (!req.we) rdata_q <= acc_rdata;
                    state <= ST_DONE;
                end
                default: begin
                    if (!ds_any) state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ebs_wait_drive.sv
module ebs_wait_drive
    import ebs_pkg::*;
#(
    parameter wait_mode_e MODE = WM_READY
) (
    input  logic sel,
    input  logic done,
    output logic rdy_pull,
    output logic ovr_pull,
    output logic ack_pull
);
    generate
        if (MODE == WM_READY) begin : g_ready
            assign rdy_pull = sel && !done;
            assign ovr_pull = 1'b0;
            assign ack_pull = 1'b0;
        end else begin : g_override
            assign rdy_pull = 1'b0;
            assign ovr_pull = sel;
            assign ack_pull = sel && done;
        end
    endgenerate
endmodule

// File: rtl/ebs_slave.sv
module ebs_slave
    import ebs_pkg::*;
#(
    parameter int                  DEC_BITS  = 4,
    parameter logic [DEC_BITS-1:0] BASE      = 'hA,
    parameter int                  WAIT_CLKS = 2,
    parameter wait_mode_e          MODE      = WM_READY
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n,
    input  logic              uds_n,
    input  logic              lds_n,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        fc,
    input  logic              bgack_n,
    input  logic              doe,
    input  logic [DATA_W-1:0] dbus_in,
    output logic [DATA_W-1:0] dbus_out,
    output logic              dbus_oe,
    output logic              acc_stb,
    output logic              acc_we,
    output logic [LANES-1:0]  acc_be,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] acc_rdata,
    output logic              rdy_pull,
    output logic              ovr_pull,
    output logic              ack_pull
);
    logic      sel;
    logic      done;
    xfer_st_e  state;
    xfer_req_t req;
    logic [DATA_W-1:0] rdata_q;

    ebs_decode #(.DEC_BITS(DEC_BITS), .BASE(BASE)) u_dec (
        .as_n(as_n), .addr(addr), .fc(fc), .bgack_n(bgack_n), .sel(sel)
    );

    ebs_xfer_ctl #(.WAIT_CLKS(WAIT_CLKS)) u_ctl (
        .clk(clk), .rst(rst), .sel(sel), .uds_n(uds_n), .lds_n(lds_n),
        .rd(rd), .addr(addr), .dbus_in(dbus_in), .acc_rdata(acc_rdata),
        .state(state), .req(req), .rdata_q(rdata_q)
    );

    assign done = (state == ST_DONE);

    ebs_wait_drive #(.MODE(MODE)) u_wd (
        .sel(sel), .done(done),
        .rdy_pull(rdy_pull), .ovr_pull(ovr_pull), .ack_pull(ack_pull)
    );

    assign acc_stb   = sel && (state == ST_ACC);
    assign acc_we    = req.we;
    assign acc_be    = req.be;
    assign acc_addr  = req.addr;
    assign acc_wdata = req.wdata;
    assign dbus_out  = rdata_q;
    assign dbus_oe   = sel && done && !req.we && doe && !(uds_n && lds_n);
endmodule

// File: rtl/ebs_chk.sv
module ebs_chk
    import ebs_pkg::*;
#(
    parameter wait_mode_e MODE = WM_READY
) (
    input logic             clk,
    input logic             rst,
    input logic             as_n,
    input logic             uds_n,
    input logic             lds_n,
    input logic             rd,
    input logic             doe,
    input logic             dbus_oe,
    input logic             acc_stb,
    input logic [LANES-1:0] acc_be,
    input logic             rdy_pull,
    input logic             ovr_pull,
    input logic             ack_pull
);
    a_r9_release_on_as_high: assert property (@(posedge clk) disable iff (rst)
        as_n |-> !(rdy_pull || ovr_pull || ack_pull || dbus_oe));

    a_r11_single_clock_pulse: assert property (@(posedge clk) disable iff (rst)
        acc_stb |=> !acc_stb);

    a_r8_oe_qualified: assert property (@(posedge clk) disable iff (rst)
        dbus_oe |-> (rd && doe && !(uds_n && lds_n)));

    a_r3_pulse_has_lane: assert property (@(posedge clk) disable iff (rst)
        acc_stb |-> (acc_be != '0));

    a_r6_ready_freed_after_access: assert property (@(posedge clk) disable iff (rst)
        acc_stb |=> !rdy_pull);

    a_r7_ack_inside_override: assert property (@(posedge clk) disable iff (rst)
        ack_pull |-> (ovr_pull && MODE == WM_OVERRIDE));
endmodule

bind ebs_slave ebs_chk #(.MODE(MODE)) u_chk (
    .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
    .rd(rd), .doe(doe), .dbus_oe(dbus_oe), .acc_stb(acc_stb),
    .acc_be(acc_be), .rdy_pull(rdy_pull), .ovr_pull(ovr_pull),
    .ack_pull(ack_pull)
);

// File: tb/sim_ebs_slave.sv
module sim_ebs_slave;
    import ebs_pkg::*;

    localparam int W = 2;

    typedef struct packed {
        logic [22:0] addr;
        logic        rd;
        logic        uds_n;
        logic        lds_n;
        logic [2:0]  fc;
        logic        bgack_n;
        logic [15:0] wd;
        logic        hit;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{23'h500010, 1'b0, 1'b0, 1'b0, 3'd5, 1'b1, 16'h1234, 1'b1},
        '{23'h500020, 1'b0, 1'b1, 1'b0, 3'd1, 1'b1, 16'hABCD, 1'b1},
        '{23'h500030, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1, 16'h5A6B, 1'b1},
        '{23'h500040, 1'b1, 1'b0, 1'b0, 3'd5, 1'b1, 16'h0000, 1'b1},
        '{23'h300040, 1'b1, 1'b0, 1'b0, 3'd5, 1'b1, 16'h0000, 1'b0},
        '{23'h500050, 1'b0, 1'b0, 1'b0, 3'd7, 1'b1, 16'h7777, 1'b0},
        '{23'h500060, 1'b0, 1'b0, 1'b0, 3'd7, 1'b0, 16'h6161, 1'b1},
        '{23'h7FFFFF, 1'b0, 1'b0, 1'b0, 3'd5, 1'b1, 16'h9999, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rd = 1'b1;
    logic [22:0] addr = '0;
    logic [2:0]  fc = 3'd5;
    logic bgack_n = 1'b1, doe = 1'b1;
    logic [15:0] dbus_in = '0;

    logic [15:0] dout0, dout1, wdat0, wdat1, rdat0, rdat1;
    logic oe0, oe1, stb0, stb1, we0, we1, rdy0, rdy1, ovr0, ovr1, ack0, ack1;
    logic [1:0]  be0, be1;
    logic [22:0] aa0, aa1;

    function automatic logic [15:0] model(input logic [22:0] a);
        return {a[7:0], ~a[7:0]};
    endfunction

    assign rdat0 = model(aa0);
    assign rdat1 = model(aa1);

    always #5 clk = ~clk;

    ebs_slave #(.WAIT_CLKS(W), .MODE(WM_READY)) u0 (
        .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
        .rd(rd), .addr(addr), .fc(fc), .bgack_n(bgack_n), .doe(doe),
        .dbus_in(dbus_in), .dbus_out(dout0), .dbus_oe(oe0), .acc_stb(stb0),
        .acc_we(we0), .acc_be(be0), .acc_addr(aa0), .acc_wdata(wdat0),
        .acc_rdata(rdat0), .rdy_pull(rdy0), .ovr_pull(ovr0), .ack_pull(ack0)
    );

    ebs_slave #(.WAIT_CLKS(W), .MODE(WM_OVERRIDE)) u1 (
        .clk(clk), .rst(rst), .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
        .rd(rd), .addr(addr), .fc(fc), .bgack_n(bgack_n), .doe(doe),
        .dbus_in(dbus_in), .dbus_out(dout1), .dbus_oe(oe1), .acc_stb(stb1),
        .acc_we(we1), .acc_be(be1), .acc_addr(aa1), .acc_wdata(wdat1),
        .acc_rdata(rdat1), .rdy_pull(rdy1), .ovr_pull(ovr1), .ack_pull(ack1)
    );

    int n_chk = 0, n_bad = 0, pulses = 0, pulses1 = 0;
    logic [15:0] cap_wd;
    logic [1:0]  cap_be;
    logic        cap_we, prev_we;
    bit          ended = 0;

    always @(negedge clk) begin
        if (stb0) begin
            pulses  <= pulses + 1;
            prev_we <= cap_we;
            cap_we  <= we0;
            cap_be  <= be0;
            cap_wd  <= wdat0;
        end
        if (stb1) pulses1 <= pulses1 + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic bus_cycle(input vec_t v);
        int p0;
        logic [1:0]  ebe;
        @(negedge clk);
        addr = v.addr; rd = v.rd; fc = v.fc; bgack_n = v.bgack_n;
        dbus_in = v.wd; as_n = 1'b0;
        p0 = pulses;
        #1;
        chk("R1/R2 ready hold", {31'd0, rdy0}, {31'd0, v.hit});
        chk("R7 override held", {31'd0, ovr1}, {31'd0, v.hit});
        @(negedge clk);
        uds_n = v.uds_n; lds_n = v.lds_n;
        repeat (6) @(negedge clk);
        #1;
        chk("R1/R2 pulse count", pulses - p0, {31'd0, v.hit});
        chk("R6 ready freed", {31'd0, rdy0}, 32'd0);
        chk("R7 own ack", {31'd0, ack1}, {31'd0, v.hit});
        chk("R8 oe on read", {31'd0, oe0}, {31'd0, v.hit && v.rd});
        if (v.hit) begin
            ebe = {!v.uds_n, !v.lds_n};
            chk("R3 byte enables", {30'd0, cap_be}, {30'd0, ebe});
            chk("R10 direction", {31'd0, cap_we}, {31'd0, !v.rd});
            if (v.rd) chk("R8 read data", {16'd0, dout0}, {16'd0, model(v.addr)});
            else      chk("R4 masked data", {16'd0, cap_wd},
                          {16'd0, (ebe[1] ? v.wd[15:8] : 8'h00), (ebe[0] ? v.wd[7:0] : 8'h00)});
        end
        uds_n = 1'b1; lds_n = 1'b1;
        #1;
        chk("R8 oe drops with strobes", {31'd0, oe0}, 32'd0);
        @(negedge clk);
        as_n = 1'b1;
        #1;
        chk("R9 released", {29'd0, rdy0, ovr1, ack1}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R11 reset no pulse", {31'd0, stb0}, 32'd0);
        chk("R9 reset no pulls", {28'd0, rdy0, ovr1, ack1, oe0}, 32'd0);

        for (int i = 0; i < NV; i++) bus_cycle(VECS[i]);

        // R5: wait count timing, ready mode
        @(negedge clk);
        addr = 23'h500100; rd = 1'b0; fc = 3'd5; bgack_n = 1'b1; as_n = 1'b0;
        @(negedge clk);
        uds_n = 1'b0; lds_n = 1'b0;
        for (int k = 1; k <= W + 2; k++) begin
            @(negedge clk);
            #1;
            chk("R5 pulse timing", {31'd0, stb0}, {31'd0, k == W + 1});
            chk("R11 pulse width", {31'd0, stb1}, {31'd0, k == W + 1});
        end
        uds_n = 1'b1; lds_n = 1'b1;
        @(negedge clk); as_n = 1'b1;

        // R10: locked read then write under one address strobe
        @(negedge clk);
        p0 = pulses;
        addr = 23'h500200; rd = 1'b1; as_n = 1'b0;
        @(negedge clk); uds_n = 1'b0; lds_n = 1'b0;
        repeat (5) @(negedge clk);
        uds_n = 1'b1; lds_n = 1'b1;
        @(negedge clk);
        rd = 1'b0; dbus_in = 16'hC3C3;
        #1;
        chk("R10 ready held between transfers", {31'd0, rdy0}, 32'd1);
        @(negedge clk); uds_n = 1'b0; lds_n = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk("R10 two pulses", pulses - p0, 32'd2);
        chk("R10 first read", {31'd0, prev_we}, 32'd0);
        chk("R10 second write", {31'd0, cap_we}, 32'd1);
        chk("R10 write data", {16'd0, cap_wd}, 32'h0000C3C3);
        uds_n = 1'b1; lds_n = 1'b1;
        @(negedge clk); as_n = 1'b1;

        // R9: abort mid-wait
        @(negedge clk);
        p0 = pulses;
        addr = 23'h500300; rd = 1'b0; as_n = 1'b0;
        @(negedge clk); uds_n = 1'b0; lds_n = 1'b0;
        @(negedge clk);
        as_n = 1'b1;
        #1;
        chk("R9 immediate release", {29'd0, rdy0, ovr1, ack1}, 32'd0);
        repeat (5) @(negedge clk);
        chk("R9 no pulse after abort", pulses - p0, 32'd0);
        uds_n = 1'b1; lds_n = 1'b1;

        // R8: output enable held off while doe low
        @(negedge clk);
        doe = 1'b0; addr = 23'h500400; rd = 1'b1; as_n = 1'b0;
        @(negedge clk); uds_n = 1'b0; lds_n = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        chk("R8 no drive without doe", {31'd0, oe0}, 32'd0);
        chk("R7 ready unused in override", {31'd0, rdy1}, 32'd0);
        uds_n = 1'b1; lds_n = 1'b1;
        @(negedge clk); as_n = 1'b1; doe = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 modes agree on count", pulses1, pulses);
        finish_run();
    end
endmodule